// File: doc/BRIEF.md
# PLL feedback divider glide controller

This block moves the feedback multiplier N of a PLL that is already running to a new value. It does not write the new value in one abrupt step. It uses the PLL's dynamic-ramp mechanism instead. After an accepted request the controller loads the two ramp step sizes and puts the PLL into slowdown mode. It waits one microsecond and writes the new N. It waits one more microsecond and enables the dynamic ramp. It then samples a ramp-complete flag once per microsecond. The flag comes from the PLL's clock domain and passes through a two-flop synchronizer first. When the flag is seen, or when the sample budget is used up, slowdown and the ramp enable are dropped in the same cycle. A one-cycle `done` pulse then reports the result, and `timeout_err` is raised with it if the ramp never completed.

The caller presents the requested N and the N currently programmed, then pulses `start`. A request whose target equals the current value completes at once and touches no PLL control. The time base is the one-cycle `tick_us` strobe, so every wait is counted in microseconds and not in clock cycles.

The state machine has four states:
- GL_IDLE waits for a request.
- GL_SETTLE holds slowdown for the first microsecond.
- GL_APPLY holds the new N for the second microsecond.
- GL_POLL samples the ramp flag.

The transitions are:
- GL_IDLE to GL_SETTLE when a request with a different N is accepted.
- GL_SETTLE to GL_APPLY on a tick, which writes N.
- GL_APPLY to GL_POLL on a tick, which enables the ramp.
- GL_POLL to GL_IDLE on a tick that sees completion or that is the last allowed sample.

Top module: `ndiv_glide_ctrl`

## Requirements
- R1: A `start` while idle with `n_target` equal to `n_current` gives `done`=1 for exactly the next cycle. `busy`, `timeout_err`, `ndiv_wr`, `slow_en`, `ramp_en`, `ndiv_out` and the step outputs do not change.
- R2: In the cycle after an accepted start (target differs from current), `step_a` reads 0x2B and `step_b` reads 0x0B. Both keep those values afterwards.
- R3: `slow_en` rises in the cycle after an accepted start, before any write of N.
- R4: On the first `tick_us` after an accepted start, `ndiv_out` takes the latched target and `ndiv_wr` pulses for one cycle.
- R5: On the next `tick_us` after the N write, `ramp_en` rises. Sampling of the ramp flag starts with the tick after that.
- R6: `ramp_done_async` is seen through two flip-flops and is only sampled on ticks in GL_POLL. The first sampled tick that sees it high clears `slow_en`, `ramp_en` and `busy` together and pulses `done`, with `timeout_err`=0.
- R7: If 500 sampled ticks all see the flag low, the 500th one performs the same exit. In that exit `timeout_err` pulses in the same cycle as `done`.
- R8: `busy` is high from the cycle after an accepted start until the exit. A `start` while busy is ignored.
- R9: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| n_target | input | N_W | Requested feedback multiplier |
| n_current | input | N_W | Multiplier currently programmed in the PLL |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| ramp_done_async | input | 1 | Ramp-complete flag from the PLL clock domain |
| step_a | output | STEP_W | First ramp step-size field |
| step_b | output | STEP_W | Second ramp step-size field |
| slow_en | output | 1 | Slowdown-mode enable |
| ndiv_out | output | N_W | N field driven to the PLL |
| ndiv_wr | output | 1 | One-cycle strobe when `ndiv_out` is written |
| ramp_en | output | 1 | Dynamic-ramp enable |
| busy | output | 1 | Glide in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Pulses with `done` when the ramp never completed |

## Verification
The assertions assume three things about the inputs:
- `tick_us` is a single-cycle strobe with at least one quiet cycle between strobes.
- `ramp_done_async` stays steady for more than two clock cycles before it is relied on.
- `n_current` is stable for the cycle in which `start` is sampled.

The stimulus meets these by generating the tick every fourth clock from a free-running counter. It changes the ramp flag and the request fields only a couple of nanoseconds after a rising edge. It holds the flag at each new level for many microseconds.

// File: rtl/ndiv_glide_pkg.sv
package ndiv_glide_pkg;

    typedef enum logic [1:0] {
        GL_IDLE   = 2'd0,
        GL_SETTLE = 2'd1,
        GL_APPLY  = 2'd2,
        GL_POLL   = 2'd3
    } glide_state_t;

endpackage

// File: rtl/ndiv_glide_sync.sv
module ndiv_glide_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ndiv_glide_pollcnt.sv
module ndiv_glide_pollcnt #(
    parameter int MAX_POLLS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);

    // R7: the sample budget is never stepped past its final slot
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last);
endmodule

// File: rtl/ndiv_glide_ctrl.sv
module ndiv_glide_ctrl
    import ndiv_glide_pkg::*;
#(
    parameter int N_W = 8,
    parameter int STEP_W = 8,
    parameter logic [STEP_W-1:0] STEP_A_VAL = 8'h2B,
    parameter logic [STEP_W-1:0] STEP_B_VAL = 8'h0B,
    parameter int MAX_POLLS = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_W-1:0]    n_target,
    input  logic [N_W-1:0]    n_current,
    input  logic              tick_us,
    input  logic              ramp_done_async,
    output logic [STEP_W-1:0] step_a,
    output logic [STEP_W-1:0] step_b,
    output logic              slow_en,
    output logic [N_W-1:0]    ndiv_out,
    output logic              ndiv_wr,
    output logic              ramp_en,
    output logic              busy,
    output logic              done,
    output logic              timeout_err
);
    glide_state_t state, state_nx;
    logic [N_W-1:0] tgt_q;
    logic ramp_seen, poll_last;
    logic same_req, accept, write_n, arm_ramp, sample, finish, fail;

    ndiv_glide_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ramp_done_async), .q_sync(ramp_seen));

    ndiv_glide_pollcnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(arm_ramp), .inc(sample && !finish),
        .last(poll_last));

    assign same_req = (state == GL_IDLE) && start && (n_target == n_current);
    assign accept   = (state == GL_IDLE) && start && (n_target != n_current);
    assign write_n  = (state == GL_SETTLE) && tick_us;
    assign arm_ramp = (state == GL_APPLY) && tick_us;
    assign sample   = (state == GL_POLL) && tick_us;
    assign finish   = sample && (ramp_seen || poll_last);
    assign fail     = sample && !ramp_seen && poll_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            GL_IDLE:   if (accept)   state_nx = GL_SETTLE;
            GL_SETTLE: if (write_n)  state_nx = GL_APPLY;
            GL_APPLY:  if (arm_ramp) state_nx = GL_POLL;
            GL_POLL:   if (finish)   state_nx = GL_IDLE;
            default:                 state_nx = GL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GL_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_a      <= '0;
            step_b      <= '0;
            slow_en     <= 1'b0;
            ndiv_out    <= '0;
            ndiv_wr     <= 1'b0;
            ramp_en     <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            tgt_q       <= '0;
        end else begin
            done        <= same_req || finish;
            timeout_err <= fail;
            ndiv_wr     <= write_n;
            if (accept) begin
                step_a  <= STEP_A_VAL;
                step_b  <= STEP_B_VAL;
                slow_en <= 1'b1;
                busy    <= 1'b1;
                tgt_q   <= n_target;
            end
            if (write_n)  ndiv_out <= tgt_q;
            if (arm_ramp) ramp_en  <= 1'b1;
            if (finish) begin
                slow_en <= 1'b0;
                ramp_en <= 1'b0;
                busy    <= 1'b0;
            end
        end
    end

    // R1: a request for the N already present completes quietly
    assert_same_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        same_req |=> done && !busy && !ndiv_wr && $stable(ndiv_out) && $stable(slow_en));

    // R3: N is only written while slowdown is on and the ramp is not yet enabled
    assert_write_in_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ndiv_wr |-> slow_en && !ramp_en);

    // R5: the ramp is only enabled with slowdown already active
    assert_ramp_after_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_en) |-> slow_en && $past(slow_en));

    // R6: slowdown and ramp enable drop in the same cycle, together with done
    assert_exit_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_en) |-> $fell(ramp_en) && done && !busy);

    // R7: a timeout is only reported as part of a completion
    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> done);

    // R8: a start while busy leaves the latched request alone
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != GL_IDLE) && start |=> $stable(tgt_q));
endmodule

// File: tb/test_ndiv_glide_ctrl.sv
module test_ndiv_glide_ctrl;
    localparam int N_W = 8;
    localparam int STEP_W = 8;
    localparam int MAX_POLLS = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N_W-1:0] n_target = '0;
    logic [N_W-1:0] n_current = '0;
    logic tick_us = 1'b0;
    logic ramp_done_async = 1'b0;
    logic [STEP_W-1:0] step_a, step_b;
    logic slow_en, ndiv_wr, ramp_en, busy, done, timeout_err;
    logic [N_W-1:0] ndiv_out;

    int vectors = 0;
    int errors = 0;

    ndiv_glide_ctrl i_ndiv_glide_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .n_target(n_target),
        .n_current(n_current), .tick_us(tick_us), .ramp_done_async(ramp_done_async),
        .step_a(step_a), .step_b(step_b), .slow_en(slow_en), .ndiv_out(ndiv_out),
        .ndiv_wr(ndiv_wr), .ramp_en(ramp_en), .busy(busy), .done(done),
        .timeout_err(timeout_err));

    always #10 clk = ~clk;

    // reference model
    int phase = 0;
    int polls = 0;
    bit hist[$];
    int e_a = 0, e_b = 0, e_slow = 0, e_n = 0, e_wr = 0, e_ramp = 0;
    int e_busy = 0, e_done = 0, e_err = 0, tgt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; polls = 0; hist.delete();
            e_a = 0; e_b = 0; e_slow = 0; e_n = 0; e_wr = 0; e_ramp = 0;
            e_busy = 0; e_done = 0; e_err = 0; tgt = 0;
        end else begin
            bit seen;
            seen = (hist.size() >= 2) ? hist[hist.size()-2] : 1'b0;
            hist.push_back(ramp_done_async);
            if (hist.size() > 4) void'(hist.pop_front());
            e_done = 0; e_err = 0; e_wr = 0;
            case (phase)
                0: if (start) begin
                    if (n_target == n_current) e_done = 1;
                    else begin
                        phase = 1; e_a = 'h2B; e_b = 'h0B; e_slow = 1;
                        e_busy = 1; tgt = int'(n_target);
                    end
                end
                1: if (tick_us) begin e_n = tgt; e_wr = 1; phase = 2; end
                2: if (tick_us) begin e_ramp = 1; phase = 3; polls = 0; end
                default: if (tick_us) begin
                    polls++;
                    if (seen || polls == MAX_POLLS) begin
                        e_done = 1; e_err = seen ? 0 : 1;
                        e_slow = 0; e_ramp = 0; e_busy = 0; phase = 0;
                    end
                end
            endcase
        end
    end

    task automatic cmp(input int act, input int exp, input string what, input string tag);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp(int'(step_a), e_a, "step_a", "R2");
            cmp(int'(step_b), e_b, "step_b", "R2");
            cmp(int'(slow_en), e_slow, "slow_en", "R3");
            cmp(int'(ndiv_out), e_n, "ndiv_out", "R4");
            cmp(int'(ndiv_wr), e_wr, "ndiv_wr", "R4");
            cmp(int'(ramp_en), e_ramp, "ramp_en", "R5");
            cmp(int'(done), e_done, "done", "R6");
            cmp(int'(timeout_err), e_err, "timeout_err", "R7");
            cmp(int'(busy), e_busy, "busy", "R8");
        end
    end

    // microsecond strobe: every fourth clock
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk); #2;
            tick_us = rst_n && (cnt == 3);
            cnt = (cnt + 1) % 4;
        end
    end

    task automatic request(input int nt, input int nc);
        @(posedge clk); #2;
        start = 1'b1; n_target = N_W'(nt); n_current = N_W'(nc);
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wait_ramp();
        @(negedge clk);
        while (!ramp_en) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            while (!tick_us) begin @(posedge clk); #1; end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL R8 watchdog: actual busy %0d expected 0", busy);
        summary();
    end

    initial begin
        // R9: outputs idle during reset
        repeat (3) @(negedge clk);
        cmp(int'({step_a, step_b, slow_en, ndiv_out, ndiv_wr, ramp_en, busy, done, timeout_err}),
            0, "reset outputs", "R9");
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R1: equal target completes at once
        request('h40, 'h40);
        @(negedge clk);
        cmp(int'(done), 1, "done on equal request", "R1");
        cmp(int'(busy), 0, "busy on equal request", "R1");
        cmp(int'(slow_en), 0, "slow_en on equal request", "R1");
        repeat (3) @(posedge clk);

        // R6: ramp completes after several samples; R8: start while busy ignored
        request('h60, 'h40);
        repeat (2) @(posedge clk);
        request('h11, 'h22);
        wait_ramp();
        wait_ticks(10);
        #1 ramp_done_async = 1'b1;
        wait_idle();
        repeat (6) @(posedge clk); #2 ramp_done_async = 1'b0;
        repeat (12) @(posedge clk);
        cmp(int'(ndiv_out), 'h60, "N after busy start", "R8");

        // R7: flag never rises
        request('h30, 'h60);
        wait_idle();
        repeat (5) @(posedge clk);

        // R6: flag already high, first sample succeeds
        #2 ramp_done_async = 1'b1;
        request('h90, 'h30);
        wait_idle();
        #2 ramp_done_async = 1'b0;
        repeat (12) @(posedge clk);

        // R7 boundary: flag arrives right at the end of the budget
        request('h25, 'h90);
        wait_ramp();
        wait_ticks(MAX_POLLS - 1);
        #1 ramp_done_async = 1'b1;
        wait_idle();
        #2 ramp_done_async = 1'b0;
        repeat (12) @(posedge clk);

        // equal request straight after a glide
        request('h25, 'h25);
        repeat (4) @(posedge clk);
        summary();
    end
endmodule